// File: doc/BRIEF.md
# Indirect Load/Store Address Unit

This block forms data-memory addresses for the byte loads and stores of a small 8-bit processor, and it keeps the pointer registers that those accesses use. It holds three 16-bit index pointers (X, Y, Z) and a 16-bit stack pointer. It accepts one decoded operation at a time. The operation carries an addressing mode, a pointer select, a 6-bit displacement, a 16-bit immediate address, a load/store flag, a destination register index and store data. The block then drives the data-memory address, read and write strobes and write data. Load results return through a registered register-file write port.

Stack pushes and pops run through the same path using the stack pointer. A program-memory byte fetch addressed by Z returns its byte to register 0. A pointer-set operation loads any of the four pointers from the immediate field, which lets the surrounding core initialise them.

Data-memory operations occupy two clocks, and the program-memory fetch occupies three. While an operation is still in flight the block raises `busy` and ignores new requests.

Top module: `ldst_addr_unit`

## Requirements
- R1: After reset, `busy`, `dm_we`, `dm_re`, `pm_re` and `rf_we` are low, and X, Y, Z and the stack pointer are 0.
- R2: Plain indirect mode (`op_mode`=0) with `op_ptr` 0=X, 1=Y or 2=Z accesses the address held in that pointer and leaves the pointer unchanged.
- R3: Post-increment mode (`op_mode`=1) accesses the pointer's current value and then writes back that value plus 1, wrapping 16'hFFFF to 16'h0000.
- R4: Pre-decrement mode (`op_mode`=2) computes pointer minus 1, accesses that address and writes it back, wrapping 16'h0000 to 16'hFFFF.
- R5: Displacement mode (`op_mode`=3) on Y or Z accesses pointer + q, where q is `op_disp` taken as unsigned 0..63 and the sum wraps modulo 2^16; the pointer is unchanged. With X selected, the request is dropped: no strobe, `busy` stays low, and X is unchanged.
- R6: Direct mode (`op_mode`=4) accesses the address `op_addr`.
- R7: In the cycle after acceptance, a store drives `dm_we` high for exactly that one cycle with `dm_wdata`=`op_wdata` and `dm_re` low. A load drives `dm_re` high instead, and in the following cycle it pulses `rf_we` with `rf_waddr`=`op_rd` and `rf_wdata` equal to the `dm_rdata` seen during the access cycle.
- R8: A data-memory operation holds `busy` high for exactly the one cycle after acceptance (two clocks in total). A request presented while `busy` is high is ignored.
- R9: Push (`op_mode`=5) stores `op_wdata` at the stack pointer and then decrements it. Pop (`op_mode`=6) increments the stack pointer, then loads from the new value into `op_rd`.
- R10: Program fetch (`op_mode`=7) drives `pm_addr`=Z with `pm_re` high in the first cycle after acceptance, keeps `busy` high for two cycles, then pulses `rf_we` with `rf_waddr`=0 and the fetched byte. Z is unchanged.
- R11: Pointer set (`op_mode`=8) loads `op_addr` into the pointer chosen by `op_ptr` (3 selects the stack pointer) in a single clock, with no memory strobe and no `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_mode | input | 4 | Addressing mode code |
| op_ptr | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 stack pointer |
| op_disp | input | 6 | Unsigned displacement q |
| op_addr | input | 16 | Direct address or pointer-set value |
| op_is_store | input | 1 | 1 store, 0 load (modes 0-4) |
| op_rd | input | 5 | Destination register for loads |
| op_wdata | input | 8 | Store/push data |
| busy | output | 1 | Operation in flight |
| dm_addr | output | 16 | Data-memory address |
| dm_we | output | 1 | Data-memory write strobe |
| dm_re | output | 1 | Data-memory read strobe |
| dm_wdata | output | 8 | Data-memory write data |
| dm_rdata | input | 8 | Data-memory read data |
| pm_addr | output | 16 | Program-memory byte address |
| pm_re | output | 1 | Program-memory read strobe |
| pm_rdata | input | 8 | Program-memory read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 8 | Register-file write data |

## Verification
The hardest situation to reach is a request arriving while an earlier access is still in flight. The ignored request must not move a pointer or start a strobe, and the earlier load's write-back must still appear intact. The stimulus holds a post-increment store on Y asserted through the busy cycle of a load. It then reads Y back with a plain access to show that the pointer stayed put. The wrap corners are reached by setting pointers to 16'hFFFF and 16'h0000 with pointer-set operations before post-increment and pre-decrement accesses. The rejected X displacement is shown by the quiet ports that follow it.

// File: rtl/lsau_pkg.sv
package lsau_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int REG_W  = 5;
    localparam int DISP_W = 6;
    localparam int NPTR   = 4;
    localparam int SEL_W  = $clog2(NPTR);

    typedef enum logic [3:0] {
        M_PLAIN   = 4'd0,
        M_POSTINC = 4'd1,
        M_PREDEC  = 4'd2,
        M_DISP    = 4'd3,
        M_DIRECT  = 4'd4,
        M_PUSH    = 4'd5,
        M_POP     = 4'd6,
        M_PROG    = 4'd7,
        M_SETPTR  = 4'd8
    } mode_e;

    localparam logic [1:0] PS_X  = 2'd0;
    localparam logic [1:0] PS_Y  = 2'd1;
    localparam logic [1:0] PS_Z  = 2'd2;
    localparam logic [1:0] PS_SP = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DACC = 2'd1,
        ST_PM1  = 2'd2,
        ST_PM2  = 2'd3
    } state_e;
endpackage

// File: rtl/lsau_ptr_bank.sv
module lsau_ptr_bank #(
    parameter int AW    = 16,
    parameter int N     = 4,
    parameter int SW    = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SW-1:0]   wr_sel,
    input  logic [AW-1:0]   wr_val,
    output logic [N*AW-1:0] ptrs
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        logic [AW-1:0] p_d, p_q;

        always_comb begin
            p_d = p_q;
            if (wr_en && (wr_sel == SW'(i)))
                p_d = wr_val;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) p_q <= '0;
            else        p_q <= p_d;
        end

        assign ptrs[i*AW +: AW] = p_q;
    end
endmodule

// File: rtl/lsau_addr_gen.sv
module lsau_addr_gen
    import lsau_pkg::*;
#(
    parameter int AW = 16,
    parameter int QW = 6,
    parameter int N  = 4
) (
    input  logic [3:0]      mode,
    input  logic [1:0]      sel,
    input  logic [QW-1:0]   disp,
    input  logic [AW-1:0]   imm,
    input  logic [N*AW-1:0] ptrs,
    output logic            legal,
    output logic            dacc,
    output logic            push,
    output logic            pop,
    output logic            prog,
    output logic [AW-1:0]   addr,
    output logic            ptr_we,
    output logic [1:0]      ptr_wsel,
    output logic [AW-1:0]   ptr_wval
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] base, zval, spv, qext;
    logic          idx_ok;

    assign base   = ptrs[sel*AW +: AW];
    assign zval   = ptrs[PS_Z*AW +: AW];
    assign spv    = ptrs[PS_SP*AW +: AW];
    assign qext   = {{(AW-QW){1'b0}}, disp};
    assign idx_ok = (sel != PS_SP);

    always_comb begin
        legal    = 1'b0;
        dacc     = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        prog     = 1'b0;
        addr     = base;
        ptr_we   = 1'b0;
        ptr_wsel = sel;
        ptr_wval = base;
        unique case (mode_e'(mode))
            M_PLAIN: begin
                legal = idx_ok;
                dacc  = idx_ok;
            end
            M_POSTINC: begin
                legal    = idx_ok;
                dacc     = idx_ok;
                ptr_we   = idx_ok;
                ptr_wval = base + ONE;
            end
            M_PREDEC: begin
                legal    = idx_ok;
                dacc     = idx_ok;
                addr     = base - ONE;
                ptr_we   = idx_ok;
                ptr_wval = base - ONE;
            end
            M_DISP: begin
                legal = (sel == PS_Y) || (sel == PS_Z);
                dacc  = legal;
                addr  = base + qext;
            end
            M_DIRECT: begin
                legal = 1'b1;
                dacc  = 1'b1;
                addr  = imm;
            end
            M_PUSH: begin
                legal    = 1'b1;
                push     = 1'b1;
                addr     = spv;
                ptr_we   = 1'b1;
                ptr_wsel = PS_SP;
                ptr_wval = spv - ONE;
            end
            M_POP: begin
                legal    = 1'b1;
                pop      = 1'b1;
                addr     = spv + ONE;
                ptr_we   = 1'b1;
                ptr_wsel = PS_SP;
                ptr_wval = spv + ONE;
            end
            M_PROG: begin
                legal = 1'b1;
                prog  = 1'b1;
                addr  = zval;
            end
            M_SETPTR: begin
                legal    = 1'b1;
                ptr_we   = 1'b1;
                ptr_wval = imm;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ldst_addr_unit.sv
module ldst_addr_unit
    import lsau_pkg::*;
#(
    parameter int AW = lsau_pkg::ADDR_W,
    parameter int DW = lsau_pkg::DATA_W,
    parameter int RW = lsau_pkg::REG_W,
    parameter int QW = lsau_pkg::DISP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_mode,
    input  logic [1:0]    op_ptr,
    input  logic [QW-1:0] op_disp,
    input  logic [AW-1:0] op_addr,
    input  logic          op_is_store,
    input  logic [RW-1:0] op_rd,
    input  logic [DW-1:0] op_wdata,
    output logic          busy,
    output logic [AW-1:0] dm_addr,
    output logic          dm_we,
    output logic          dm_re,
    output logic [DW-1:0] dm_wdata,
    input  logic [DW-1:0] dm_rdata,
    output logic [AW-1:0] pm_addr,
    output logic          pm_re,
    input  logic [DW-1:0] pm_rdata,
    output logic          rf_we,
    output logic [RW-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata
);
    localparam int NP = lsau_pkg::NPTR;

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] addr;
        logic          we;
        logic          re;
        logic [DW-1:0] wd;
        logic [RW-1:0] rd;
        logic          rfwe;
        logic [RW-1:0] rfwa;
        logic [DW-1:0] rfwd;
        logic [DW-1:0] hold;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NP*AW-1:0] ptrs;
    logic             g_legal, g_dacc, g_push, g_pop, g_prog, g_pwe;
    logic [AW-1:0]    g_addr, g_pwval;
    logic [1:0]       g_pwsel;
    logic             accept;

    lsau_addr_gen #(.AW(AW), .QW(QW), .N(NP)) u_agen (
        .mode     (op_mode),
        .sel      (op_ptr),
        .disp     (op_disp),
        .imm      (op_addr),
        .ptrs     (ptrs),
        .legal    (g_legal),
        .dacc     (g_dacc),
        .push     (g_push),
        .pop      (g_pop),
        .prog     (g_prog),
        .addr     (g_addr),
        .ptr_we   (g_pwe),
        .ptr_wsel (g_pwsel),
        .ptr_wval (g_pwval)
    );

    assign accept = op_valid && (ctl_q.st == ST_IDLE) && g_legal;

    lsau_ptr_bank #(.AW(AW), .N(NP), .SW(2)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept && g_pwe),
        .wr_sel (g_pwsel),
        .wr_val (g_pwval),
        .ptrs   (ptrs)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.we   = 1'b0;
        ctl_d.re   = 1'b0;
        ctl_d.rfwe = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.addr = g_addr;
                    ctl_d.rd   = op_rd;
                    if (g_dacc || g_push || g_pop) begin
                        ctl_d.st = ST_DACC;
                        if (g_push || (g_dacc && op_is_store)) begin
                            ctl_d.we = 1'b1;
                            ctl_d.wd = op_wdata;
                        end else begin
                            ctl_d.re = 1'b1;
                        end
                    end else if (g_prog) begin
                        ctl_d.st = ST_PM1;
                    end
                end
            end
            ST_DACC: begin
                ctl_d.st = ST_IDLE;
                if (ctl_q.re) begin
                    ctl_d.rfwe = 1'b1;
                    ctl_d.rfwa = ctl_q.rd;
                    ctl_d.rfwd = dm_rdata;
                end
            end
            ST_PM1: begin
                ctl_d.hold = pm_rdata;
                ctl_d.st   = ST_PM2;
            end
            ST_PM2: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.rfwe = 1'b1;
                ctl_d.rfwa = '0;
                ctl_d.rfwd = ctl_q.hold;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy     = (ctl_q.st != ST_IDLE);
    assign dm_addr  = ctl_q.addr;
    assign dm_we    = ctl_q.we;
    assign dm_re    = ctl_q.re;
    assign dm_wdata = ctl_q.wd;
    assign pm_addr  = ctl_q.addr;
    assign pm_re    = (ctl_q.st == ST_PM1);
    assign rf_we    = ctl_q.rfwe;
    assign rf_waddr = ctl_q.rfwa;
    assign rf_wdata = ctl_q.rfwd;
endmodule

// File: rtl/lsau_chk.sv
module lsau_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [3:0]  op_mode,
    input logic [1:0]  op_ptr,
    input logic [15:0] op_addr,
    input logic        busy,
    input logic [15:0] dm_addr,
    input logic        dm_we,
    input logic        dm_re,
    input logic        pm_re,
    input logic        rf_we,
    input logic [4:0]  rf_waddr
);
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> !dm_re);

    a_r7_store_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |=> !dm_we);

    a_r7_load_return: assert property (@(posedge clk) disable iff (!rst_n)
        dm_re |=> rf_we);

    a_r8_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_we || dm_re) |-> busy);

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pm_re) |=> !busy);

    a_r10_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pm_re |=> (busy && !pm_re && !rf_we));

    a_r10_prog_wb: assert property (@(posedge clk) disable iff (!rst_n)
        pm_re |=> ##1 (rf_we && rf_waddr == 5'd0));

    a_r5_x_disp_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_mode == 4'd3 && op_ptr == 2'd0)
        |=> (!busy && !dm_we && !dm_re));

    a_r6_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_mode == 4'd4) |=> (dm_addr == $past(op_addr)));
endmodule

bind ldst_addr_unit lsau_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_mode  (op_mode),
    .op_ptr   (op_ptr),
    .op_addr  (op_addr),
    .busy     (busy),
    .dm_addr  (dm_addr),
    .dm_we    (dm_we),
    .dm_re    (dm_re),
    .pm_re    (pm_re),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr)
);

// File: tb/sim_ldst_addr_unit.sv
module sim_ldst_addr_unit;
    localparam time TCLK = 10ns;

    localparam logic [3:0] PLAIN = 4'd0, POSTI = 4'd1, PRED = 4'd2, DISP = 4'd3,
                           DIRK = 4'd4, PUSH = 4'd5, POP = 4'd6, PROG = 4'd7, SETP = 4'd8;
    localparam logic [1:0] PX = 2'd0, PY = 2'd1, PZ = 2'd2, PSP = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_mode = '0;
    logic [1:0]  op_ptr = '0;
    logic [5:0]  op_disp = '0;
    logic [15:0] op_addr = '0;
    logic        op_is_store = 1'b0;
    logic [4:0]  op_rd = '0;
    logic [7:0]  op_wdata = '0;
    logic        busy, dm_we, dm_re, pm_re, rf_we;
    logic [15:0] dm_addr, pm_addr;
    logic [7:0]  dm_wdata, dm_rdata, pm_rdata, rf_wdata;
    logic [4:0]  rf_waddr;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(TCLK/2) clk = ~clk;

    function automatic logic [7:0] dmf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    function automatic logic [7:0] pmf(input logic [15:0] a);
        return (a[7:0] + 8'h3C) ^ a[15:8];
    endfunction

    assign dm_rdata = dmf(dm_addr);
    assign pm_rdata = pmf(pm_addr);

    ldst_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
        .op_ptr(op_ptr), .op_disp(op_disp), .op_addr(op_addr),
        .op_is_store(op_is_store), .op_rd(op_rd), .op_wdata(op_wdata),
        .busy(busy), .dm_addr(dm_addr), .dm_we(dm_we), .dm_re(dm_re),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .pm_addr(pm_addr),
        .pm_re(pm_re), .pm_rdata(pm_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // drives one request for one clock; returns at the negedge of the cycle after
    task automatic issue(input logic [3:0] m, input logic [1:0] s, input logic [5:0] q,
                         input logic [15:0] k, input logic st, input logic [4:0] rd,
                         input logic [7:0] wd);
        @(negedge clk);
        op_valid = 1'b1; op_mode = m; op_ptr = s; op_disp = q;
        op_addr = k; op_is_store = st; op_rd = rd; op_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic access(input logic [3:0] m, input logic [1:0] s, input logic [5:0] q,
                          input logic [15:0] k, input logic st, input logic [4:0] rd,
                          input logic [7:0] wd, input logic [15:0] ea, input string req);
        issue(m, s, q, k, st, rd, wd);
        chk({req, " busy in access"}, busy, 1);
        chk({req, " address"}, dm_addr, ea);
        chk({req, " dm_we"}, dm_we, st);
        chk({req, " dm_re"}, dm_re, !st);
        if (st) chk({req, " R7 store data"}, dm_wdata, wd);
        @(negedge clk);
        chk({req, " R8 busy released"}, busy, 0);
        chk({req, " R7 rf_we"}, rf_we, !st);
        if (!st) begin
            chk({req, " R7 rf_waddr"}, rf_waddr, rd);
            chk({req, " R7 rf_wdata"}, rf_wdata, dmf(ea));
        end
    endtask

    task automatic peek(input logic [1:0] s, input logic [15:0] ev, input string req);
        access(PLAIN, s, 6'd0, 16'h0, 1'b0, 5'd1, 8'h0, ev, {req, " readback"});
    endtask

    task automatic setp(input logic [1:0] s, input logic [15:0] v);
        issue(SETP, s, 6'd0, v, 1'b0, 5'd0, 8'h0);
        chk("R11 set busy", busy, 0);
        chk("R11 set no strobe", {dm_we, dm_re, pm_re}, 0);
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 strobes", {dm_we, dm_re, pm_re, rf_we}, 0);
        peek(PX, 16'h0000, "R1 X");
        peek(PY, 16'h0000, "R1 Y");
        peek(PZ, 16'h0000, "R1 Z");
    endtask

    task automatic t_plain;
        setp(PX, 16'h1234);
        access(PLAIN, PX, 6'd0, 16'h0, 1'b0, 5'd9, 8'h0, 16'h1234, "R2 load X");
        access(PLAIN, PX, 6'd0, 16'h0, 1'b1, 5'd0, 8'h5C, 16'h1234, "R2 store X");
        peek(PX, 16'h1234, "R2 X kept");
        setp(PZ, 16'h8001);
        access(PLAIN, PZ, 6'd0, 16'h0, 1'b0, 5'd31, 8'h0, 16'h8001, "R2 load Z");
    endtask

    task automatic t_postinc;
        setp(PY, 16'h00FF);
        access(POSTI, PY, 6'd0, 16'h0, 1'b0, 5'd4, 8'h0, 16'h00FF, "R3 load Y old");
        peek(PY, 16'h0100, "R3 Y+1");
        setp(PZ, 16'hFFFF);
        access(POSTI, PZ, 6'd0, 16'h0, 1'b1, 5'd0, 8'hE1, 16'hFFFF, "R3 store Z");
        peek(PZ, 16'h0000, "R3 Z wrap");
    endtask

    task automatic t_predec;
        setp(PX, 16'h0010);
        access(PRED, PX, 6'd0, 16'h0, 1'b0, 5'd2, 8'h0, 16'h000F, "R4 load X new");
        peek(PX, 16'h000F, "R4 X-1");
        setp(PX, 16'h0000);
        access(PRED, PX, 6'd0, 16'h0, 1'b1, 5'd0, 8'h3A, 16'hFFFF, "R4 store wrap");
        peek(PX, 16'hFFFF, "R4 X wrap");
    endtask

    task automatic t_disp;
        setp(PY, 16'h2000);
        access(DISP, PY, 6'd63, 16'h0, 1'b0, 5'd6, 8'h0, 16'h203F, "R5 Y+63");
        peek(PY, 16'h2000, "R5 Y kept");
        setp(PZ, 16'hFFF0);
        access(DISP, PZ, 6'd32, 16'h0, 1'b1, 5'd0, 8'h99, 16'h0010, "R5 Z+32 wrap");
        access(DISP, PZ, 6'd0, 16'h0, 1'b0, 5'd7, 8'h0, 16'hFFF0, "R5 Z+0");
        setp(PX, 16'h4444);
        issue(DISP, PX, 6'd5, 16'h0, 1'b0, 5'd3, 8'h0);
        chk("R5 X disp no busy", busy, 0);
        chk("R5 X disp no strobe", {dm_we, dm_re}, 0);
        @(negedge clk);
        chk("R5 X disp no rf write", rf_we, 0);
        peek(PX, 16'h4444, "R5 X kept");
    endtask

    task automatic t_direct;
        access(DIRK, PX, 6'd0, 16'hBEEF, 1'b0, 5'd12, 8'h0, 16'hBEEF, "R6 load");
        access(DIRK, PX, 6'd0, 16'h0001, 1'b1, 5'd0, 8'h7E, 16'h0001, "R6 store");
    endtask

    task automatic t_busy;
        setp(PY, 16'h0300);
        issue(PLAIN, PZ, 6'd0, 16'h0, 1'b0, 5'd20, 8'h0);
        chk("R8 busy", busy, 1);
        // present a post-increment store on Y during the busy cycle
        op_valid = 1'b1; op_mode = POSTI; op_ptr = PY; op_is_store = 1'b1; op_wdata = 8'hAA;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R8 ignored no store", dm_we, 0);
        chk("R8 busy low", busy, 0);
        chk("R8 first load rf_we", rf_we, 1);
        chk("R8 first load rf_waddr", rf_waddr, 5'd20);
        peek(PY, 16'h0300, "R8 Y untouched");
    endtask

    task automatic t_stack;
        setp(PSP, 16'h0100);
        access(PUSH, PX, 6'd0, 16'h0, 1'b1, 5'd0, 8'h77, 16'h0100, "R9 push 1");
        access(PUSH, PX, 6'd0, 16'h0, 1'b1, 5'd0, 8'h88, 16'h00FF, "R9 push 2");
        access(POP, PX, 6'd0, 16'h0, 1'b0, 5'd17, 8'h0, 16'h00FF, "R9 pop 1");
        access(POP, PX, 6'd0, 16'h0, 1'b0, 5'd18, 8'h0, 16'h0100, "R9 pop 2");
    endtask

    task automatic t_prog;
        setp(PZ, 16'h0345);
        issue(PROG, PX, 6'd0, 16'h0, 1'b0, 5'd7, 8'h0);
        chk("R10 busy c1", busy, 1);
        chk("R10 pm_re c1", pm_re, 1);
        chk("R10 pm_addr", pm_addr, 16'h0345);
        chk("R10 no dm strobe", {dm_we, dm_re}, 0);
        @(negedge clk);
        chk("R10 busy c2", busy, 1);
        chk("R10 pm_re c2", pm_re, 0);
        chk("R10 no early rf", rf_we, 0);
        @(negedge clk);
        chk("R10 busy c3", busy, 0);
        chk("R10 rf_we", rf_we, 1);
        chk("R10 rf_waddr r0", rf_waddr, 5'd0);
        chk("R10 rf_wdata", rf_wdata, pmf(16'h0345));
        peek(PZ, 16'h0345, "R10 Z kept");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_postinc();
        t_predec();
        t_disp();
        t_direct();
        t_busy();
        t_stack();
        t_prog();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule